// File: doc/BRIEF.md
# Output-Stationary Convolution MAC Array

This block computes one tile of a convolution layer. A small array of multiply-accumulate lanes covers a 2x2 window of output pixels for two output channels at once. Each lane keeps its partial sum in its own register until the sum is complete. The kernel columns, the kernel rows and the input channels are stepped serially, one product per lane per cycle. Only after every product of a group is added does the array move to the next output window or output-channel pair.

The block reads from on-chip buffers that already hold the input tile and the weights. Those buffers return data one cycle after the address. Each pixel lane has its own read port, and every output-channel lane has one weight port. A single weight word feeds all pixel lanes of its channel, and a single pixel word feeds both channel lanes. When a group finishes, all eight results leave together, each with its own destination address. The stride, kernel size, input-channel count and output tile size are runtime inputs. They are captured when a run starts.

Top module: `conv_mac_array`

## Requirements
- R1: After reset, busy, done and outValid are low.
- R2: A start while busy is low captures all configuration inputs, and busy is high from the next cycle. A start while busy is high is ignored, so the running job's results and timing do not change even if the configuration inputs change.
- R3: For kernel offset (kx,ky), input channel ic and pixel lane p = ly*2+lx, pixAddr lane p is (ic*tiy + oy*S+ky)*tix + ox*S+kx. Here ox = oxg*2+lx, oy = oyg*2+ly, tix = (tileW-1)*S + kernelW and tiy = (tileH-1)*S + kernelH. The lane's AW-bit field sits at bits p*AW upward.
- R4: Weight lane c reads address ((oc*inChans + ic)*kernelH + ky)*kernelW + kx, where oc = ofg*2+c. Its field sits at bits c*AW upward.
- R5: One MAC is issued per cycle. kx changes fastest, then ky, then ic. The first address set appears in the cycle after the start is accepted. With K = kernelW*kernelH*inChans, the first outValid is in cycle K+2 after that edge, and later outValids follow every K cycles.
- R6: Each result is the signed sum of all K products of 8-bit signed pixels and weights, as a 24-bit two's-complement value. The accumulator clears on the first product of its group and is never written to a buffer.
- R7: Output lane o = (c*2+ly)*2+lx carries its result at outData bits o*24 upward. Its address (oc*tileH + oy)*tileW + ox is at outAddr bits o*AW upward.
- R8: Groups advance with the x window fastest, then the y window, then the output-channel pair. There are (tileW/2)*(tileH/2)*(tileChans/2) groups in total. Every size must be at least 1, and the tile sizes must be even.
- R9: done is high for exactly one cycle, in the cycle after the final outValid. busy goes low in the cycle after done.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Starts a job when idle |
| stride | input | CW | Window step S |
| kernelW | input | CW | Kernel columns |
| kernelH | input | CW | Kernel rows |
| inChans | input | CW | Input channels |
| tileW | input | CW | Output tile width (even) |
| tileH | input | CW | Output tile height (even) |
| tileChans | input | CW | Output channels in tile (even) |
| busy | output | 1 | Job in progress |
| done | output | 1 | One-cycle completion pulse |
| pixAddr | output | 4*AW | Pixel read address per pixel lane |
| pixData | input | 4*DW | Pixel word per lane, one cycle after its address |
| wtAddr | output | 2*AW | Weight read address per channel lane |
| wtData | input | 2*DW | Weight word per lane, one cycle after its address |
| outValid | output | 1 | Results of a finished group are present |
| outData | output | 8*ACW | Eight signed results |
| outAddr | output | 8*AW | Destination address per result |

## Verification
Two functions can fall in the same cycle. In the cycle where one group's results are on outData, the accumulators also take the first product of the next group, which clears the old sum. This overlap is hardest to get right with a 1x1 kernel and one input channel, because every cycle is then both a first and a last product and outValid stays high for several cycles in a row. Such a job is run and each cycle's results are compared with a reference convolution. Any result taken after the clear, or any clear that was missed, shows up as a wrong sum on a specific lane.

// File: rtl/conv_pkg.sv
package conv_pkg;
  // strobes from the loop controller to the MAC datapath
  typedef struct packed {
    logic mac;    // a product is issued this cycle
    logic first;  // first product of a group: clear accumulators
    logic last;   // last product of a group
    logic fin;    // last product of the whole job
  } strobe_t;
endpackage

// File: rtl/conv_ctrl.sv
module conv_ctrl
  import conv_pkg::*;
#(
  parameter int POX = 2,
  parameter int POY = 2,
  parameter int POF = 2,
  parameter int CW  = 8,
  parameter int AW  = 12
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    start,
  input  logic [CW-1:0]           stride,
  input  logic [CW-1:0]           kernelW,
  input  logic [CW-1:0]           kernelH,
  input  logic [CW-1:0]           inChans,
  input  logic [CW-1:0]           tileW,
  input  logic [CW-1:0]           tileH,
  input  logic [CW-1:0]           tileChans,
  input  logic                    doneIn,
  output logic                    busy,
  output strobe_t                 strb,
  output logic [POX*POY*AW-1:0]   pixAddr,
  output logic [POF*AW-1:0]       wtAddr,
  output logic [POF*POY*POX*AW-1:0] grpAddr
);
  localparam logic [CW-1:0] ONE  = CW'(1);
  localparam logic [CW-1:0] POXC = CW'(POX);
  localparam logic [CW-1:0] POYC = CW'(POY);
  localparam logic [CW-1:0] POFC = CW'(POF);

  logic          run;
  logic [CW-1:0] sR, nkxR, nkyR, nifR, toxR, toyR, tofR;
  logic [CW-1:0] kx, ky, ic, oxg, oyg, ofg;
  logic kxEnd, kyEnd, icEnd, oxEnd, oyEnd, ofEnd, innerEnd, allEnd;

  assign kxEnd    = (kx  == nkxR - ONE);
  assign kyEnd    = (ky  == nkyR - ONE);
  assign icEnd    = (ic  == nifR - ONE);
  assign oxEnd    = (oxg == toxR / POXC - ONE);
  assign oyEnd    = (oyg == toyR / POYC - ONE);
  assign ofEnd    = (ofg == tofR / POFC - ONE);
  assign innerEnd = kxEnd && kyEnd && icEnd;
  assign allEnd   = oxEnd && oyEnd && ofEnd;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy <= 1'b0; run <= 1'b0;
      sR <= '0; nkxR <= '0; nkyR <= '0; nifR <= '0;
      toxR <= '0; toyR <= '0; tofR <= '0;
      kx <= '0; ky <= '0; ic <= '0; oxg <= '0; oyg <= '0; ofg <= '0;
    end else begin
      if (start && !busy) begin
        busy <= 1'b1; run <= 1'b1;
        sR <= stride; nkxR <= kernelW; nkyR <= kernelH; nifR <= inChans;
        toxR <= tileW; toyR <= tileH; tofR <= tileChans;
        kx <= '0; ky <= '0; ic <= '0; oxg <= '0; oyg <= '0; ofg <= '0;
      end else if (run) begin
        if (!kxEnd) kx <= kx + ONE;
        else begin
          kx <= '0;
          if (!kyEnd) ky <= ky + ONE;
          else begin
            ky <= '0;
            if (!icEnd) ic <= ic + ONE;
            else begin
              ic <= '0;
              if (!oxEnd) oxg <= oxg + ONE;
              else begin
                oxg <= '0;
                if (!oyEnd) oyg <= oyg + ONE;
                else begin
                  oyg <= '0;
                  if (!ofEnd) ofg <= ofg + ONE;
                  else run <= 1'b0;
                end
              end
            end
          end
        end
      end
      if (doneIn) busy <= 1'b0;
    end
  end

  assign strb.mac   = run;
  assign strb.first = run && (kx == '0) && (ky == '0) && (ic == '0);
  assign strb.last  = run && innerEnd;
  assign strb.fin   = run && innerEnd && allEnd;

  // address arithmetic in AW bits
  logic [AW-1:0] sW, nkxW, nkyW, nifW, toxW, toyW, kxW, kyW, icW;
  logic [AW-1:0] oxgW, oygW, ofgW, tix, tiy;
  assign sW   = AW'(sR);   assign nkxW = AW'(nkxR); assign nkyW = AW'(nkyR);
  assign nifW = AW'(nifR); assign toxW = AW'(toxR); assign toyW = AW'(toyR);
  assign kxW  = AW'(kx);   assign kyW  = AW'(ky);   assign icW  = AW'(ic);
  assign oxgW = AW'(oxg);  assign oygW = AW'(oyg);  assign ofgW = AW'(ofg);
  assign tix  = (toxW - AW'(1)) * sW + nkxW;
  assign tiy  = (toyW - AW'(1)) * sW + nkyW;

  for (genvar ly = 0; ly < POY; ly++) begin : g_py
    for (genvar lx = 0; lx < POX; lx++) begin : g_px
      logic [AW-1:0] px, py;
      assign px = (oxgW * AW'(POX) + AW'(lx)) * sW + kxW;
      assign py = (oygW * AW'(POY) + AW'(ly)) * sW + kyW;
      assign pixAddr[(ly*POX+lx)*AW +: AW] = (icW * tiy + py) * tix + px;
    end
  end

  for (genvar c = 0; c < POF; c++) begin : g_ch
    logic [AW-1:0] oc;
    assign oc = ofgW * AW'(POF) + AW'(c);
    assign wtAddr[c*AW +: AW] = ((oc * nifW + icW) * nkyW + kyW) * nkxW + kxW;
    for (genvar ly = 0; ly < POY; ly++) begin : g_oy
      for (genvar lx = 0; lx < POX; lx++) begin : g_ox
        assign grpAddr[((c*POY+ly)*POX+lx)*AW +: AW] =
          (oc * toyW + oygW * AW'(POY) + AW'(ly)) * toxW + oxgW * AW'(POX) + AW'(lx);
      end
    end
  end

  // R5
  kx_range_chk: assert property (@(posedge clk) disable iff (!rstN) run |-> (kx < nkxR));
  // R2
  start_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
  // R9
  issue_stop_chk: assert property (@(posedge clk) disable iff (!rstN) strb.fin |=> !strb.mac);
endmodule

// File: rtl/conv_datapath.sv
module conv_datapath
  import conv_pkg::*;
#(
  parameter int POX = 2,
  parameter int POY = 2,
  parameter int POF = 2,
  parameter int DW  = 8,
  parameter int PW  = 16,
  parameter int ACW = 24,
  parameter int AW  = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  strobe_t                     strb,
  input  logic [POX*POY*DW-1:0]       pixData,
  input  logic [POF*DW-1:0]           wtData,
  input  logic [POF*POY*POX*AW-1:0]   grpAddr,
  output logic                        outValid,
  output logic [POF*POY*POX*ACW-1:0]  outData,
  output logic [POF*POY*POX*AW-1:0]   outAddr,
  output logic                        done
);
  localparam int NPIX = POX * POY;
  localparam int NOUT = POF * NPIX;

  strobe_t                strbD;
  logic [NOUT*AW-1:0]     addrD;
  logic                   outFinal;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      strbD <= '0; addrD <= '0; outAddr <= '0;
      outValid <= 1'b0; outFinal <= 1'b0; done <= 1'b0;
    end else begin
      strbD    <= strb;
      addrD    <= grpAddr;
      outValid <= strbD.mac && strbD.last;
      outFinal <= strbD.fin;
      if (strbD.last) outAddr <= addrD;
      done     <= outValid && outFinal;
    end
  end

  for (genvar c = 0; c < POF; c++) begin : g_c
    for (genvar p = 0; p < NPIX; p++) begin : g_p
      logic signed [DW-1:0]  pix, wt;
      logic signed [PW-1:0]  prod;
      logic signed [ACW-1:0] acc;
      assign pix  = pixData[p*DW +: DW];
      assign wt   = wtData[c*DW +: DW];
      assign prod = PW'(pix) * PW'(wt);
      always_ff @(posedge clk) begin
        if (!rstN) acc <= '0;
        else if (strbD.mac)
          acc <= (strbD.first ? '0 : acc) + {{(ACW-PW){prod[PW-1]}}, prod};
      end
      assign outData[(c*NPIX+p)*ACW +: ACW] = acc;
    end
  end

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN) done |=> !done);
  // R9
  done_after_out_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |-> $past(outValid));
  // R5
  strobe_order_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.last |-> strb.mac);
  // R6
  clear_on_issue_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.first |-> strb.mac);
endmodule

// File: rtl/conv_mac_array.sv
module conv_mac_array
  import conv_pkg::*;
#(
  parameter int POX = 2,
  parameter int POY = 2,
  parameter int POF = 2,
  parameter int DW  = 8,
  parameter int PW  = 16,
  parameter int ACW = 24,
  parameter int CW  = 8,
  parameter int AW  = 12
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        start,
  input  logic [CW-1:0]               stride,
  input  logic [CW-1:0]               kernelW,
  input  logic [CW-1:0]               kernelH,
  input  logic [CW-1:0]               inChans,
  input  logic [CW-1:0]               tileW,
  input  logic [CW-1:0]               tileH,
  input  logic [CW-1:0]               tileChans,
  output logic                        busy,
  output logic                        done,
  output logic [POX*POY*AW-1:0]       pixAddr,
  input  logic [POX*POY*DW-1:0]       pixData,
  output logic [POF*AW-1:0]           wtAddr,
  input  logic [POF*DW-1:0]           wtData,
  output logic                        outValid,
  output logic [POF*POY*POX*ACW-1:0]  outData,
  output logic [POF*POY*POX*AW-1:0]   outAddr
);
  strobe_t                   strb;
  logic [POF*POY*POX*AW-1:0] grpAddr;

  conv_ctrl #(.POX(POX), .POY(POY), .POF(POF), .CW(CW), .AW(AW)) u_ctrl (
    .clk, .rstN, .start, .stride, .kernelW, .kernelH, .inChans,
    .tileW, .tileH, .tileChans, .doneIn(done), .busy, .strb,
    .pixAddr, .wtAddr, .grpAddr
  );

  conv_datapath #(.POX(POX), .POY(POY), .POF(POF), .DW(DW), .PW(PW),
                  .ACW(ACW), .AW(AW)) u_dp (
    .clk, .rstN, .strb, .pixData, .wtData, .grpAddr,
    .outValid, .outData, .outAddr, .done
  );
endmodule

// File: tb/conv_mac_array_test.sv
module conv_mac_array_test;
  localparam int AW = 12;
  logic clk = 1'b0, rstN = 1'b0, start = 1'b0;
  logic [7:0] stride, kernelW, kernelH, inChans, tileW, tileH, tileChans;
  logic busy, done, outValid;
  logic [4*AW-1:0] pixAddr;
  logic [31:0]     pixData;
  logic [2*AW-1:0] wtAddr;
  logic [15:0]     wtData;
  logic [8*24-1:0] outData;
  logic [8*AW-1:0] outAddr;

  logic signed [7:0] pixMem [4096];
  logic signed [7:0] wtMem  [4096];
  int checks = 0, errors = 0;
  int cS, cKx, cKy, cNi, cTx, cTy, cTf;

  always #10 clk = ~clk;

  conv_mac_array uut (
    .clk, .rstN, .start, .stride, .kernelW, .kernelH, .inChans,
    .tileW, .tileH, .tileChans, .busy, .done, .pixAddr, .pixData,
    .wtAddr, .wtData, .outValid, .outData, .outAddr
  );

  always_ff @(posedge clk) begin
    for (int p = 0; p < 4; p++) pixData[p*8 +: 8] <= pixMem[pixAddr[p*AW +: AW]];
    for (int c = 0; c < 2; c++) wtData[c*8 +: 8] <= wtMem[wtAddr[c*AW +: AW]];
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int refSum(int oc, int oy, int ox);
    int tix = (cTx-1)*cS + cKx, tiy = (cTy-1)*cS + cKy, s = 0;
    for (int i = 0; i < cNi; i++)
      for (int y = 0; y < cKy; y++)
        for (int x = 0; x < cKx; x++)
          s += int'(pixMem[(i*tiy + oy*cS+y)*tix + ox*cS+x]) *
               int'(wtMem[((oc*cNi+i)*cKy+y)*cKx+x]);
    return s;
  endfunction

  function automatic int sext24(logic [23:0] v);
    return int'({{8{v[23]}}, v});
  endfunction

  task automatic drive(int s, int kx, int ky, int ni, int tx, int ty, int tf);
    stride = 8'(s); kernelW = 8'(kx); kernelH = 8'(ky); inChans = 8'(ni);
    tileW = 8'(tx); tileH = 8'(ty); tileChans = 8'(tf);
  endtask

  task automatic runConv(int s, int kx, int ky, int ni, int tx, int ty, int tf, bit interfere);
    int K, G, gx, gy, tix, n;
    cS = s; cKx = kx; cKy = ky; cNi = ni; cTx = tx; cTy = ty; cTf = tf;
    K = kx*ky*ni; gx = tx/2; gy = ty/2; G = gx*gy*(tf/2);
    tix = (tx-1)*s + kx;
    for (int i = 0; i < 4096; i++) begin
      pixMem[i] = 8'($urandom);
      wtMem[i]  = 8'($urandom);
    end
    @(negedge clk);
    drive(s, kx, ky, ni, tx, ty, tf);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 1;
    chk(busy == 1'b1, "R2 busy after start", int'(busy), 1);
    for (int p = 0; p < 4; p++)
      chk(int'(pixAddr[p*AW +: AW]) == (p/2)*s*tix + (p%2)*s, "R3 first pixel address",
          int'(pixAddr[p*AW +: AW]), (p/2)*s*tix + (p%2)*s);
    for (int c = 0; c < 2; c++)
      chk(int'(wtAddr[c*AW +: AW]) == c*ni*ky*kx, "R4 first weight address",
          int'(wtAddr[c*AW +: AW]), c*ni*ky*kx);
    while (n <= G*K + 4) begin
      bit expV;
      if (interfere && n == 3) begin drive(1, 1, 1, 1, 2, 2, 2); start = 1'b1; end
      if (interfere && n == 4) begin start = 1'b0; drive(s, kx, ky, ni, tx, ty, tf); end
      if (n == 2 && kx > 1) begin
        chk(int'(pixAddr[0 +: AW]) == s*0 + 1, "R5 kx steps first", int'(pixAddr[0 +: AW]), 1);
        chk(int'(wtAddr[0 +: AW]) == 1, "R5 kx steps first weight", int'(wtAddr[0 +: AW]), 1);
      end
      expV = (n >= K+2) && ((n-2) % K == 0) && ((n-2)/K <= G);
      if (expV || outValid) chk(outValid == expV, "R5 outValid timing", int'(outValid), int'(expV));
      if (expV && outValid) begin
        int grp = (n-2)/K - 1;
        int oxg = grp % gx, oyg = (grp / gx) % gy, ofg = grp / (gx*gy);
        for (int o = 0; o < 8; o++) begin
          int c = o/4, ly = (o/2)%2, lx = o%2;
          int oc = ofg*2+c, oy = oyg*2+ly, ox = oxg*2+lx;
          int ea = (oc*ty + oy)*tx + ox;
          int ev = refSum(oc, oy, ox);
          int av = sext24(outData[o*24 +: 24]);
          chk(int'(outAddr[o*AW +: AW]) == ea, "R7 R8 output address",
              int'(outAddr[o*AW +: AW]), ea);
          chk(av == ev, interfere ? "R2 R6 sum after ignored start" : "R6 sum", av, ev);
        end
      end
      if (n == G*K + 2 || n == G*K + 3)
        chk(done == (n == G*K + 3), "R9 done pulse", int'(done), int'(n == G*K + 3));
      if (n == G*K + 3) chk(busy == 1'b1, "R9 busy during done", int'(busy), 1);
      if (n == G*K + 4) chk(busy == 1'b0, "R9 busy after done", int'(busy), 0);
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int wd = 0;
    while (wd < 150000) begin @(posedge clk); wd++; end
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    drive(1, 1, 1, 1, 2, 2, 2);
    repeat (3) @(negedge clk);
    // R1
    chk(busy == 1'b0, "R1 busy reset", int'(busy), 0);
    chk(done == 1'b0, "R1 done reset", int'(done), 0);
    chk(outValid == 1'b0, "R1 outValid reset", int'(outValid), 0);
    rstN = 1'b1;
    // 1x1, one channel: output every cycle, clear and present overlap
    runConv(1, 1, 1, 1, 4, 4, 4, 1'b0);
    runConv(2, 3, 3, 2, 4, 4, 4, 1'b0);
    runConv(1, 3, 3, 3, 4, 2, 2, 1'b1);
    runConv(2, 1, 1, 3, 2, 4, 2, 1'b0);
    runConv(1, 3, 2, 1, 2, 2, 2, 1'b0);
    for (int r = 0; r < 8; r++)
      runConv(1 + int'($urandom % 2), 1 + int'($urandom % 3), 1 + int'($urandom % 3),
              1 + int'($urandom % 3), 2 * (1 + int'($urandom % 2)),
              2 * (1 + int'($urandom % 2)), 2 * (1 + int'($urandom % 2)), r == 3);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule